// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned 32-bit operands and an incoming carry and returns the 32-bit sum with the outgoing carry. It is purely combinational, so there is no clock, no reset and no register anywhere in it. Every bit position forms a generate term (both operand bits set) and a propagate term (either operand bit set). The word is split into four 8-bit groups. Each group computes its internal carries from flattened sum-of-products equations, so no carry inside a group waits on another carry. Each group also reports a group generate and a group propagate.

A second-level lookahead unit takes the group terms and the incoming carry. It forms the carry into every group and the final carry-out, again as flattened products. The parameter `RIPPLE_GROUPS` selects a smaller variant. In that variant each group's own carry-out drives the next group's carry-in, and the second-level unit is not built. Both variants give the same numeric result and differ only in logic depth and area.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals bits 31..0 of the unsigned value `a_i + b_i + carry_i` for every input combination.
- R2: `carry_o` equals bit 32 of the unsigned value `a_i + b_i + carry_i`.
- R3: Inside each 8-bit group, the carry leaving the group equals the group generate OR (the group propagate AND the carry entering the group). The group generate is set when some bit generates and every higher bit in the group propagates. The group propagate is the AND of the eight bit propagates.
- R4: In the default variant (`RIPPLE_GROUPS`=0), the second-level unit forms the carries into bits 8, 16 and 24 and the final carry. Each carry it forms equals the carry-out of the group below it.
- R5: A carry entering at bit 0 travels through all four groups. All-ones plus a carry-in of 1 gives `sum_o`=0 and `carry_o`=1. 0x00FFFFFF plus 1 gives 0x01000000.
- R6: The variant with `RIPPLE_GROUPS`=1 produces the same `sum_o` and `carry_o` as the default variant for every input.
- R7: With both operands zero, `sum_o` equals `carry_i` and `carry_o` is 0.
- R8: The outputs depend only on the current inputs. A new input value is reflected on the outputs within the same time step, without any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand, unsigned |
| b_i | input | 32 | Second operand, unsigned |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Low 32 bits of the sum |
| carry_o | output | 1 | Carry out of bit 31 |

## Verification
Every result of this adder is combinational, so the sum and the carry are due in the same time step in which the operands change. The bench therefore applies each vector one time unit after a clock edge and samples both outputs at the following falling edge, well after the inputs have settled and well before the next vector arrives. Both variants are instantiated side by side on the same inputs. Each is compared with a 33-bit reference sum computed in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned GROUP_W = 8;
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = cla_pkg::GROUP_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  logic [W-1:0] gen, prop;
  logic [W:0]   carry;

  assign gen  = a_i & b_i;
  assign prop = a_i | b_i;

  // flattened carries: each one is a sum of products of g, p and cin only
  always_comb begin
    logic term, prod;
    carry[0] = cin_i;
    for (int j = 0; j < int'(W); j++) begin
      term = cin_i;
      for (int m = 0; m <= j; m++) term &= prop[m];
      for (int k = 0; k <= j; k++) begin
        prod = gen[k];
        for (int m = k + 1; m <= j; m++) prod &= prop[m];
        term |= prod;
      end
      carry[j+1] = term;
    end
  end

  always_comb begin
    logic prod;
    grp_gen_o = 1'b0;
    for (int k = 0; k < int'(W); k++) begin
      prod = gen[k];
      for (int m = k + 1; m < int'(W); m++) prod &= prop[m];
      grp_gen_o |= prod;
    end
  end

  assign grp_prop_o = &prop;
  assign sum_o      = a_i ^ b_i ^ carry[W-1:0];
  assign cout_o     = carry[W];

  always_comb begin
    // R3
    grp_carry_chk: assert (cout_o == (grp_gen_o | (grp_prop_o & cin_i)))
      else $error("group carry disagrees with group G/P");
  end
endmodule

// File: rtl/cla_level2.sv
module cla_level2 #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] grp_gen_i,
  input  logic [N-1:0] grp_prop_i,
  input  logic         cin_i,
  output logic [N:0]   grp_cin_o
);
  // carry into group j+1 from c0 and group terms only, no chaining
  always_comb begin
    logic term, prod;
    grp_cin_o[0] = cin_i;
    for (int j = 0; j < int'(N); j++) begin
      term = cin_i;
      for (int m = 0; m <= j; m++) term &= grp_prop_i[m];
      for (int k = 0; k <= j; k++) begin
        prod = grp_gen_i[k];
        for (int m = k + 1; m <= j; m++) prod &= grp_prop_i[m];
        term |= prod;
      end
      grp_cin_o[j+1] = term;
    end
  end

  always_comb begin
    // R4
    level2_first_chk: assert (grp_cin_o[1] == (grp_gen_i[0] | (grp_prop_i[0] & cin_i)))
      else $error("second-level carry into group 1 wrong");
  end
endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder #(
  parameter int unsigned WIDTH         = cla_pkg::WORD_W,
  parameter int unsigned GRP_W         = cla_pkg::GROUP_W,
  parameter bit          RIPPLE_GROUPS = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned NGRP = WIDTH / GRP_W;

  logic [NGRP-1:0] grp_gen, grp_prop, grp_cout;
  logic [NGRP:0]   grp_cin;

  for (genvar i = 0; i < NGRP; i++) begin : g_grp
    cla_group #(.W(GRP_W)) i_grp (
      .a_i       (a_i[i*GRP_W +: GRP_W]),
      .b_i       (b_i[i*GRP_W +: GRP_W]),
      .cin_i     (grp_cin[i]),
      .sum_o     (sum_o[i*GRP_W +: GRP_W]),
      .cout_o    (grp_cout[i]),
      .grp_gen_o (grp_gen[i]),
      .grp_prop_o(grp_prop[i])
    );
  end

  if (RIPPLE_GROUPS) begin : g_ripple
    assign grp_cin = {grp_cout, carry_i};
    always_comb begin
      // R3
      ripple_top_chk: assert (grp_cout[NGRP-1] ==
          (grp_gen[NGRP-1] | (grp_prop[NGRP-1] & grp_cin[NGRP-1])))
        else $error("top group carry disagrees with its G/P");
    end
  end else begin : g_look
    cla_level2 #(.N(NGRP)) i_level2 (
      .grp_gen_i (grp_gen),
      .grp_prop_i(grp_prop),
      .cin_i     (carry_i),
      .grp_cin_o (grp_cin)
    );
    always_comb begin
      // R4
      level2_match_chk: assert (grp_cin[NGRP:1] == grp_cout)
        else $error("second-level carries differ from group carry-outs");
    end
  end

  assign carry_o = grp_cin[NGRP];

  always_comb begin
    // R1
    sum_value_chk: assert (sum_o == WIDTH'(a_i + b_i + WIDTH'(carry_i)))
      else $error("sum mismatch");
    // R2
    carry_value_chk: assert (carry_o ==
        (({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(carry_i)) >> WIDTH))
      else $error("carry mismatch");
  end
endmodule

// File: tb/test_lookahead_adder.sv
module test_lookahead_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic        cin;
  logic [31:0] sum_l, sum_r;
  logic        co_l, co_r;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  lookahead_adder i_lookahead_adder (
    .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum_l), .carry_o(co_l));

  lookahead_adder #(.RIPPLE_GROUPS(1'b1)) i_lookahead_adder_rpl (
    .a_i(a), .b_i(b), .carry_i(cin), .sum_o(sum_r), .carry_o(co_r));

  function automatic logic [32:0] ref_add(logic [31:0] x, logic [31:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + 33'(c);
  endfunction

  task automatic check(string tag);
    logic [32:0] exp;
    exp = ref_add(a, b, cin);
    n_chk++;
    if ({co_l, sum_l} !== exp) begin
      n_err++;
      $display("FAIL %s lookahead: got %b_%h exp %b_%h", tag, co_l, sum_l, exp[32], exp[31:0]);
    end
    n_chk++;
    if ({co_r, sum_r} !== exp) begin
      n_err++;
      $display("FAIL %s R6 ripple: got %b_%h exp %b_%h", tag, co_r, sum_r, exp[32], exp[31:0]);
    end
  endtask

  // R8: drive just after a rising edge, sample at the falling edge
  task automatic apply(logic [31:0] x, logic [31:0] y, logic c, string tag);
    @(posedge clk); #1;
    a = x; b = y; cin = c;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle zero");
    apply(32'h0, 32'h0, 1'b1, "R7 carry only");
    apply(32'hFFFF_FFFF, 32'h0, 1'b1, "R5 all ones plus cin");
    apply(32'h00FF_FFFF, 32'h1, 1'b0, "R5 R4 cross three groups");
    apply(32'h0000_00FF, 32'h0000_0001, 1'b0, "R4 c8");
    apply(32'h0000_FF00, 32'h0000_0100, 1'b0, "R4 c16 generate");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R3 alternating propagate");
    apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "R2 alternating carry out");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 msb carry");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1 max");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = (i % 4 == 0) ? ~x : $urandom;
      apply(x, y, 1'($urandom), "R1 R2 random");
    end
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'd281));
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule